// File: doc/BRIEF.md
# Segmented-Paging Address Translator

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. A base register points at a table of segment descriptors in memory, and a length register sets how many descriptors that table holds. Each descriptor carries the segment's length, its read/write/execute rights, a valid flag and the address of a page table that belongs to that segment alone. Once the descriptor checks pass, the upper part of the offset selects an entry in that page table, and the entry supplies the physical frame.

Requests arrive one at a time with an access type. Both tables are fetched through one word-wide memory read port that uses a request/acknowledge handshake. Every accepted request ends with a single-cycle response. The response carries either a physical address or a fault flag with a 3-bit cause. The block makes no memory reads past the first failing check, and it makes none at all for a segment number out of range.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req` and `resp_valid` are 0. A request is taken only while `req_ready` is 1. `req_ready` stays 0 from the taking of a request that needs memory until its response.
- R2: When `{0,req_seg}` is not below `stlr`, the response has cause 1 in the cycle after acceptance and no memory read is made.
- R3: The descriptor word with limit and flags is read first, at `stbr + seg*8 + 4`. The page-table base word is read next, at `stbr + seg*8`, and only when all descriptor checks pass.
- R4: Descriptor bit 31 is the valid flag. When it is 0 the cause is 2, and this check comes before the limit and permission checks.
- R5: Descriptor bits 23:0 hold the segment length in bytes. An offset equal to or above it faults with cause 3, ahead of the permission check. A length of 0 makes every offset fault.
- R6: `req_acc` encodes 0 as read, 1 as write and 2 as execute. These need descriptor bits 30, 29 and 28 respectively, and code 3 is never allowed. A denied access faults with cause 4.
- R7: The page entry is read at `pt_base + off[23:12]*4`. When its bit 0 is 0 the cause is 5.
- R8: On success `resp_fault` is 0, the cause is 0 and `resp_paddr` is `{pte[31:12], off[11:0]}`. On any fault `resp_fault` is 1, the cause is nonzero and `resp_paddr` is 0.
- R9: `resp_valid` lasts one cycle for each accepted request. `mem_req` and `mem_addr` are held steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stbr | input | 32 | Byte address of the segment descriptor table |
| stlr | input | 9 | Number of descriptors in the table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to take a request |
| req_seg | input | 8 | Segment number |
| req_off | input | 24 | Byte offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data word |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Translation faulted |
| resp_cause | output | 3 | Fault cause, 0 when no fault |
| resp_paddr | output | 32 | Physical address |

## Verification
The assertions check the following on every cycle: the response lasts exactly one cycle, the fault flag agrees with the cause code, a faulted address reads as zero, a memory request is held steady until acknowledged, and the idle state issues no reads. They also check that the first read after a legal request goes to the descriptor's flag word and that an out-of-range segment answers at once without a read. Only the bench's sweep over segments, offsets at and around each limit, and all four access codes shows the rest. That covers the priority order among the causes, the frame spliced into the right physical address, and the exact number of memory reads each outcome costs.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEGHI = 2'd1,
    ST_SEGLO = 2'd2,
    ST_PTE   = 2'd3
  } st_e;

  localparam logic [2:0] C_NONE         = 3'd0;
  localparam logic [2:0] C_SEG_RANGE    = 3'd1;
  localparam logic [2:0] C_SEG_INVALID  = 3'd2;
  localparam logic [2:0] C_LIMIT        = 3'd3;
  localparam logic [2:0] C_PERM         = 3'd4;
  localparam logic [2:0] C_PAGE_INVALID = 3'd5;

  localparam int SEG_VALID_BIT = 31;
  localparam int PERM_RD_BIT   = 30;
  localparam int PERM_WR_BIT   = 29;
  localparam int PERM_EX_BIT   = 28;
  localparam int PTE_VALID_BIT = 0;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;
endpackage

// File: rtl/spx_rst_sync.sv
module spx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/spx_seg_check.sv
module spx_seg_check
  import spx_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input  logic [31:0]      desc_hi,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  output logic [2:0]       cause
);
  logic perm_ok;

  always_comb begin
    case (acc)
      ACC_RD:  perm_ok = desc_hi[PERM_RD_BIT];
      ACC_WR:  perm_ok = desc_hi[PERM_WR_BIT];
      ACC_EX:  perm_ok = desc_hi[PERM_EX_BIT];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!desc_hi[SEG_VALID_BIT])        cause = C_SEG_INVALID;
    else if (off >= desc_hi[OFF_W-1:0]) cause = C_LIMIT;
    else if (!perm_ok)                  cause = C_PERM;
    else                                cause = C_NONE;
  end
endmodule

// File: rtl/spx_addr_gen.sv
module spx_addr_gen
  import spx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEG_W = 8,
  parameter int IDX_W = 12
) (
  input  st_e              st,
  input  logic [AW-1:0]    stbr,
  input  logic [SEG_W-1:0] seg,
  input  logic [AW-1:0]    pt_base,
  input  logic [IDX_W-1:0] pg_idx,
  output logic [AW-1:0]    addr
);
  localparam int DESC_SHIFT = 3;
  localparam int PTE_SHIFT  = 2;

  logic [AW-1:0] desc_addr;

  assign desc_addr = stbr + (AW'(seg) << DESC_SHIFT);

  always_comb begin
    case (st)
      ST_SEGHI: addr = desc_addr + AW'(4);
      ST_SEGLO: addr = desc_addr;
      ST_PTE:   addr = pt_base + (AW'(pg_idx) << PTE_SHIFT);
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEG_W = 8,
  parameter int OFF_W = 24,
  parameter int PG_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    stbr,
  input  logic [SEG_W:0]   stlr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [2:0]       resp_cause,
  output logic [AW-1:0]    resp_paddr
);
  localparam int IDX_W = OFF_W - PG_W;

  logic             rst_s;
  st_e              st_q, st_d;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic [AW-1:0]    ptb_q;
  logic             take_en, ptb_en;
  logic             rv_d, rf_d, rf_q;
  logic [2:0]       rc_d, rc_q;
  logic [AW-1:0]    rp_d, rp_q;
  logic             rv_q;
  logic             seg_legal;
  logic [2:0]       desc_cause;

  spx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  spx_seg_check #(.OFF_W(OFF_W)) u_chk_desc (
    .desc_hi (mem_rdata),
    .off     (off_q),
    .acc     (acc_q),
    .cause   (desc_cause)
  );

  spx_addr_gen #(.AW(AW), .SEG_W(SEG_W), .IDX_W(IDX_W)) u_addr (
    .st      (st_q),
    .stbr    (stbr),
    .seg     (seg_q),
    .pt_base (ptb_q),
    .pg_idx  (off_q[OFF_W-1:PG_W]),
    .addr    (mem_addr)
  );

  assign seg_legal = {1'b0, req_seg} < stlr;
  assign req_ready = (st_q == ST_IDLE) && rst_s;
  assign mem_req   = (st_q != ST_IDLE);

  always_comb begin
    st_d    = st_q;
    take_en = 1'b0;
    ptb_en  = 1'b0;
    rv_d    = 1'b0;
    rf_d    = rf_q;
    rc_d    = rc_q;
    rp_d    = rp_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && rst_s) begin
          take_en = 1'b1;
          if (!seg_legal) begin
            rv_d = 1'b1;
            rf_d = 1'b1;
            rc_d = C_SEG_RANGE;
            rp_d = '0;
          end else begin
            st_d = ST_SEGHI;
          end
        end
      end
      ST_SEGHI: begin
        if (mem_ack) begin
          if (desc_cause != C_NONE) begin
            rv_d = 1'b1;
            rf_d = 1'b1;
            rc_d = desc_cause;
            rp_d = '0;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_SEGLO;
          end
        end
      end
      ST_SEGLO: begin
        if (mem_ack) begin
          ptb_en = 1'b1;
          st_d   = ST_PTE;
        end
      end
      default: begin
        if (mem_ack) begin
          rv_d = 1'b1;
          st_d = ST_IDLE;
          if (!mem_rdata[PTE_VALID_BIT]) begin
            rf_d = 1'b1;
            rc_d = C_PAGE_INVALID;
            rp_d = '0;
          end else begin
            rf_d = 1'b0;
            rc_d = C_NONE;
            rp_d = {mem_rdata[AW-1:PG_W], off_q[PG_W-1:0]};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
      rf_q <= 1'b0;
      rc_q <= C_NONE;
      rp_q <= '0;
    end else if (!rst_s) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      rf_q <= rf_d;
      rc_q <= rc_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      off_q <= '0;
      acc_q <= '0;
    end else if (take_en) begin
      seg_q <= req_seg;
      off_q <= req_off;
      acc_q <= req_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptb_q <= '0;
    end else if (ptb_en) begin
      ptb_q <= mem_rdata;
    end
  end

  assign resp_valid = rv_q;
  assign resp_fault = rf_q;
  assign resp_cause = rc_q;
  assign resp_paddr = rp_q;
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
  parameter int AW    = 32,
  parameter int SEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    stbr,
  input logic [SEG_W:0]   stlr,
  input logic             req_valid,
  input logic             req_ready,
  input logic [SEG_W-1:0] req_seg,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ack,
  input logic             resp_valid,
  input logic             resp_fault,
  input logic [2:0]       resp_cause,
  input logic [AW-1:0]    resp_paddr
);
  logic take_legal, take_range;
  assign take_legal = req_valid && req_ready && ({1'b0, req_seg} < stlr);
  assign take_range = req_valid && req_ready && !({1'b0, req_seg} < stlr);

  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    take_legal |=> !req_ready);

  a_r2_range_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    take_range |=> resp_valid && resp_fault && resp_cause == 3'd1 && !mem_req);

  a_r3_first_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    take_legal |=> mem_req &&
      mem_addr == $past(stbr) + {{(AW-SEG_W-3){1'b0}}, $past(req_seg), 3'b100});

  a_r8_fault_cause_agree: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_fault == (resp_cause != 3'd0)) && resp_cause <= 3'd5);

  a_r8_fault_paddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_paddr == '0);

  a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

bind seg_page_xlate spx_checker #(.AW(AW), .SEG_W(SEG_W)) u_spx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .stbr       (stbr),
  .stlr       (stlr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_seg    (req_seg),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .resp_valid (resp_valid),
  .resp_fault (resp_fault),
  .resp_cause (resp_cause),
  .resp_paddr (resp_paddr)
);

// File: tb/seg_page_xlate_tb.sv
`timescale 1ns/1ps
module seg_page_xlate_tb;
  logic        clk, rst_n;
  logic [31:0] stbr;
  logic [8:0]  stlr;
  logic        req_valid, req_ready;
  logic [7:0]  req_seg;
  logic [23:0] req_off;
  logic [1:0]  req_acc;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        resp_valid, resp_fault;
  logic [2:0]  resp_cause;
  logic [31:0] resp_paddr;

  int checks = 0;
  int fails  = 0;
  int nreads = 0;
  logic [31:0] mem [0:1023];

  localparam logic [31:0] TBL = 32'h40;

  seg_page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .stbr(stbr), .stlr(stlr),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_cause(resp_cause), .resp_paddr(resp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [23:0] seg_lim(input int s);
    case (s)
      0: return 24'h2800;
      1: return 24'h4000;
      2: return 24'h1001;
      3: return 24'h3000;
      4: return 24'h10000;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [2:0] seg_perm(input int s);
    case (s)
      0: return 3'b110;
      1: return 3'b101;
      4: return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic seg_ok(input int s);
    return s != 3;
  endfunction

  function automatic logic pg_ok(input int s, input int i);
    return ((s + i) % 4) != 3;
  endfunction

  function automatic logic [19:0] pg_frame(input int s, input int i);
    return 20'h80000 + 20'(s * 256 + i * 3);
  endfunction

  task automatic model(input int s, input logic [23:0] off, input int acc,
                       input int stl, output int cause, output logic [31:0] pa);
    logic [2:0] p;
    logic       ok;
    int         i;
    p  = seg_perm(s);
    ok = (acc == 0) ? p[2] : (acc == 1) ? p[1] : (acc == 2) ? p[0] : 1'b0;
    i  = int'(off[23:12]);
    pa = 32'h0;
    if (s >= stl) cause = 1;
    else if (s > 5 || !seg_ok(s)) cause = 2;
    else if (off >= seg_lim(s)) cause = 3;
    else if (!ok) cause = 4;
    else if (!pg_ok(s, i)) cause = 5;
    else begin
      cause = 0;
      pa = {pg_frame(s, i), off[11:0]};
    end
  endtask

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        nreads++;
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xlate(input int s, input logic [23:0] off, input int acc, input int stl);
    int          ec, er, k;
    logic [31:0] ep;
    model(s, off, acc, stl, ec, ep);
    er = (ec == 1) ? 0 : (ec == 2 || ec == 3 || ec == 4) ? 1 : 3;
    @(negedge clk);
    nreads    = 0;
    req_valid = 1'b1;
    req_seg   = 8'(s);
    req_off   = off;
    req_acc   = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
    if (ec != 1) check("R1 busy ready", {63'h0, req_ready}, 64'h0);
    k = 0;
    while (!resp_valid && k < 60) begin
      @(negedge clk);
      k++;
    end
    // R2 R4 R5 R6 R7 R8: cause, fault and physical address
    check($sformatf("R8 seg=%0d off=%0h acc=%0d", s, off, acc),
          {28'h0, resp_fault, resp_cause, resp_paddr},
          {28'h0, ec != 0, 3'(ec), ep});
    // R2 R3 R7: read count per outcome
    check($sformatf("R3 reads seg=%0d off=%0h acc=%0d", s, off, acc),
          64'(nreads), 64'(er));
    @(negedge clk);
    check("R9 pulse", {63'h0, resp_valid}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] offs [7];
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0; req_acc = '0;
    stbr = TBL; stlr = 9'd4;
    for (int w = 0; w < 1024; w++) mem[w] = 32'h0;
    for (int s = 0; s < 6; s++) begin
      mem[(TBL >> 2) + 2 * s]     = 32'h400 + 32'(s * 32'h40);
      mem[(TBL >> 2) + 2 * s + 1] = {seg_ok(s), seg_perm(s), 4'h0, seg_lim(s)};
      for (int i = 0; i < 16; i++)
        mem[((32'h400 + 32'(s * 32'h40)) >> 2) + i] = {pg_frame(s, i), 11'h0, pg_ok(s, i)};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset ready", {63'h0, req_ready}, 64'h1);
    check("R1 reset mem_req", {63'h0, mem_req}, 64'h0);
    check("R1 reset resp_valid", {63'h0, resp_valid}, 64'h0);

    for (int s = 0; s < 6; s++) begin
      offs[0] = 24'h0;
      offs[1] = 24'h123;
      offs[2] = 24'h1FFF;
      offs[3] = 24'h2ABC;
      offs[4] = seg_lim(s) - 24'h1;
      offs[5] = seg_lim(s);
      offs[6] = 24'hFFFFFF;
      for (int o = 0; o < 7; o++)
        for (int a = 0; a < 4; a++)
          xlate(s, offs[o], a, 4);
    end

    stlr = 9'd256;
    for (int a = 0; a < 4; a++) begin
      xlate(4, 24'h0, a, 256);
      xlate(4, 24'hF7FF, a, 256);
      xlate(255, 24'h10, a, 256);
    end
    stlr = 9'd0;
    xlate(0, 24'h0, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule